// File: doc/BRIEF.md
# Prescaled Timer with Input Modes

An 8-bit down-counting timer fed by a 6-bit prescaler. Software-facing write strobes carry three settings: a control word (run, load request, pin mode), an initial count, and a prescaler word (divide ratio, reload mode, clock source). The present count can be read at any time on `count_o`. A divide ratio or initial count of zero stands for the full range of its field. This gives 64 for the prescaler and 256 for the counter.

The prescaler advances on every internal clock cycle, or it follows an external input pin. The pin first passes through a synchroniser. In the internal-clock selection the pin is unused. Otherwise a 2-bit pin mode selects its role:
- counted clock edges;
- a gate on the internal clock;
- a one-shot trigger that ignores further edges while a count is running;
- a trigger that restarts the count on every edge.

At terminal count the timer either stops at zero or reloads its initial value and carries on. It also raises a one-cycle end-of-count pulse.

Top module: `prescaled_timer`

## Requirements
- R1: The initial count is 1 to 256 prescaler ticks: a written value N counts N ticks, and a written 0 counts 256 ticks (the count shows 255 after the first tick).
- R2: The counter takes one tick every D prescaler advances, with D equal to `pre_div`, or 64 when `pre_div` is 0. With `pre_internal`=1, one advance occurs on every clock cycle while running.
- R3: With `pre_modulo`=0, the count stops at 0 after the tick from 1 and stays there. With `pre_modulo`=1, the tick from 1 reloads the initial value and counting continues.
- R4: `eoc_o` is high for exactly the one cycle after the clock edge on which the count ticks from 1. It stays low at every other time.
- R5: A control write with `cfg_load`=1 copies the initial value into the count on that edge and restarts the prescaler. A control write with `cfg_load`=0 leaves the count untouched.
- R6: With `cfg_run`=0 the count is frozen. A control write with `cfg_run`=1 starts advancing from the next edge.
- R7: `count_o` returns the current count. Writing a new initial value does not change it.
- R8: With `pre_internal`=0 and pin mode 2'b00, each synchronised rising edge of `ext_pin` is one prescaler advance.
- R9: With `pre_internal`=0 and pin mode 2'b01, the prescaler advances on each cycle that the synchronised pin is high, and only on those cycles.
- R10: With `pre_internal`=0 and pin mode 2'b10, a load arms the timer without counting. The first pin rising edge loads the initial value and starts counting on the internal clock. Later edges are ignored while the count is in progress.
- R11: With `pre_internal`=0 and pin mode 2'b11, every pin rising edge reloads the initial value, restarts the prescaler and counts on the internal clock.
- R12: After reset the count is 0, `eoc_o` is low, the timer is stopped, and the divide ratio reads as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_run | input | 1 | Run (1) or freeze (0) |
| cfg_load | input | 1 | 1 requests a load of the initial value |
| cfg_pin_mode | input | 2 | 00 clock, 01 gate, 10 one-shot trigger, 11 restart trigger |
| init_wr | input | 1 | Initial count write strobe |
| init_val | input | CW | Initial count (0 means full range) |
| pre_wr | input | 1 | Prescaler word write strobe |
| pre_div | input | PW | Divide ratio (0 means full range) |
| pre_modulo | input | 1 | 1 reloads at terminal count, 0 stops |
| pre_internal | input | 1 | 1 selects the internal clock, 0 selects the pin mode |
| ext_pin | input | 1 | Asynchronous external timing input |
| count_o | output | CW | Current count |
| eoc_o | output | 1 | One-cycle end-of-count pulse |

## Verification
Several properties are checked on every cycle:
- an end-of-count pulse only follows a tick from 1;
- a stopped counter and a frozen timer hold their value;
- a modulo wrap lands on the initial value;
- a prescaler restart clears it;
- a synchronised rising edge lasts one cycle.

Only the bench scenarios can show the exact tick counts. These include the full-range zero encodings, the gate window width, and whether a second trigger edge is ignored or restarts the count, each against values worked out from the synchroniser latency.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        PIN_CLOCK     = 2'b00,
        PIN_GATE      = 2'b01,
        PIN_TRIG_ONCE = 2'b10,
        PIN_TRIG_RE   = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/ptmr_pin_sync.sv
module ptmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain = {sync_q.chain[DEPTH-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level_o = sync_q.chain[STAGES-1];
    assign rise_o  = sync_q.chain[STAGES-1] & ~sync_q.chain[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R8

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          restart_i,
    input  logic [PW-1:0] div_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PW-1:0] last;

    always_comb begin
        // a ratio of 0 wraps to the all-ones last step: full range
        last   = div_i - 1'b1;
        tick_o = adv_i && !restart_i && (pre_q.cnt == last);
        pre_d  = pre_q;
        if (restart_i)   pre_d.cnt = '0;
        else if (tick_o) pre_d.cnt = '0;
        else if (adv_i)  pre_d.cnt = pre_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pre_q.cnt == '0)); // R5

endmodule

// File: rtl/ptmr_count_core.sv
module ptmr_count_core #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tick_i,
    input  logic          modulo_i,
    input  logic [CW-1:0] init_i,
    output logic [CW-1:0] cnt_o,
    output logic          live_o,
    output logic          eoc_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          live;
        logic          eoc;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d     = core_q;
        core_d.eoc = 1'b0;
        if (start_i) begin
            core_d.cnt  = init_i;
            core_d.live = 1'b1;
        end else if (tick_i && core_q.live) begin
            if (core_q.cnt == ONE) begin
                core_d.eoc  = 1'b1;
                core_d.cnt  = modulo_i ? init_i : '0;
                core_d.live = modulo_i;
            end else begin
                core_d.cnt = core_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign cnt_o  = core_q.cnt;
    assign live_o = core_q.live;
    assign eoc_o  = core_q.eoc;

    AST_EOC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.eoc |-> $past(tick_i && !start_i && core_q.cnt == ONE)); // R4

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_q.live && !start_i) |=> $stable(core_q.cnt)); // R3

    AST_MOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !start_i && core_q.live && modulo_i && core_q.cnt == ONE)
        |=> (core_q.cnt == $past(init_i))); // R3

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
    parameter int CW          = 8,
    parameter int PW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_run,
    input  logic          cfg_load,
    input  logic [1:0]    cfg_pin_mode,
    input  logic          init_wr,
    input  logic [CW-1:0] init_val,
    input  logic          pre_wr,
    input  logic [PW-1:0] pre_div,
    input  logic          pre_modulo,
    input  logic          pre_internal,
    input  logic          ext_pin,
    output logic [CW-1:0] count_o,
    output logic          eoc_o
);
    import ptmr_pkg::*;

    typedef struct packed {
        logic          run;
        pin_mode_e     mode;
        logic [CW-1:0] init;
        logic [PW-1:0] div;
        logic          modulo;
        logic          internal;
        logic          fired;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic pin_level, pin_rise;
    logic load_req, trig_mode, trig_start, start, adv, tick, live;

    ptmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (ext_pin),
        .level_o (pin_level),
        .rise_o  (pin_rise)
    );

    always_comb begin
        load_req  = cfg_wr && cfg_load;
        trig_mode = !ctl_q.internal &&
                    (ctl_q.mode == PIN_TRIG_ONCE || ctl_q.mode == PIN_TRIG_RE);

        // a one-shot trigger is ignored while a triggered count runs
        trig_start = 1'b0;
        if (ctl_q.run && trig_mode && pin_rise && !load_req) begin
            if (ctl_q.mode == PIN_TRIG_RE) trig_start = 1'b1;
            else                           trig_start = !(ctl_q.fired && live);
        end
        start = load_req || trig_start;

        adv = 1'b0;
        if (ctl_q.run) begin
            if (ctl_q.internal) begin
                adv = 1'b1;
            end else begin
                unique case (ctl_q.mode)
                    PIN_CLOCK:     adv = pin_rise;
                    PIN_GATE:      adv = pin_level;
                    PIN_TRIG_ONCE: adv = ctl_q.fired;
                    PIN_TRIG_RE:   adv = ctl_q.fired;
                    default:       adv = 1'b0;
                endcase
            end
        end

        ctl_d = ctl_q;
        if (cfg_wr) begin
            ctl_d.run  = cfg_run;
            ctl_d.mode = pin_mode_e'(cfg_pin_mode);
        end
        if (init_wr) ctl_d.init = init_val;
        if (pre_wr) begin
            ctl_d.div      = pre_div;
            ctl_d.modulo   = pre_modulo;
            ctl_d.internal = pre_internal;
        end
        if (load_req)        ctl_d.fired = 1'b0;
        else if (trig_start) ctl_d.fired = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: PIN_CLOCK, default: '0};
        else        ctl_q <= ctl_d;
    end

    ptmr_prescaler #(.PW(PW)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv),
        .restart_i (start),
        .div_i     (ctl_q.div),
        .tick_o    (tick)
    );

    ptmr_count_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .tick_i   (tick),
        .modulo_i (ctl_q.modulo),
        .init_i   (ctl_q.init),
        .cnt_o    (count_o),
        .live_o   (live),
        .eoc_o    (eoc_o)
    );

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ctl_q.run); // R6

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !load_req) |=> $stable(count_o)); // R6

endmodule

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, cfg_run = 1'b0, cfg_load = 1'b0;
    logic [1:0]    cfg_pin_mode = 2'b00;
    logic          init_wr = 1'b0;
    logic [CW-1:0] init_val = '0;
    logic          pre_wr = 1'b0;
    logic [PW-1:0] pre_div = '0;
    logic          pre_modulo = 1'b0, pre_internal = 1'b0;
    logic          ext_pin = 1'b0;
    logic [CW-1:0] count_o;
    logic          eoc_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prescaled_timer #(.CW(CW), .PW(PW)) u_prescaled_timer (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_run(cfg_run), .cfg_load(cfg_load),
        .cfg_pin_mode(cfg_pin_mode),
        .init_wr(init_wr), .init_val(init_val),
        .pre_wr(pre_wr), .pre_div(pre_div),
        .pre_modulo(pre_modulo), .pre_internal(pre_internal),
        .ext_pin(ext_pin), .count_o(count_o), .eoc_o(eoc_o)
    );

    typedef struct packed {
        logic [7:0]  init;
        logic [5:0]  div;
        logic        modulo;
        logic [15:0] wait_n;
        logic [7:0]  exp;
    } vec_t;

    // internal clock; wait_n = edges after the load edge
    localparam vec_t VEC [8] = '{
        '{8'd5,   6'd1, 1'b0, 16'd3,   8'd2},   // R2
        '{8'd5,   6'd1, 1'b0, 16'd7,   8'd0},   // R3 single pass stops
        '{8'd10,  6'd4, 1'b0, 16'd9,   8'd8},   // R2
        '{8'd0,   6'd1, 1'b0, 16'd1,   8'd255}, // R1 zero is 256
        '{8'd0,   6'd0, 1'b0, 16'd128, 8'd254}, // R1 R2 zero is 64
        '{8'd3,   6'd1, 1'b1, 16'd4,   8'd2},   // R3 modulo wrap
        '{8'd1,   6'd1, 1'b1, 16'd5,   8'd1},   // R3 modulo of 1
        '{8'd200, 6'd0, 1'b0, 16'd192, 8'd197}  // R2
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_init(input logic [CW-1:0] v);
        init_wr = 1'b1; init_val = v;
        step(1);
        init_wr = 1'b0;
    endtask

    task automatic write_pre(input logic [PW-1:0] d, input logic m, input logic i);
        pre_wr = 1'b1; pre_div = d; pre_modulo = m; pre_internal = i;
        step(1);
        pre_wr = 1'b0;
    endtask

    task automatic write_cfg(input logic run, input logic load, input logic [1:0] mode);
        cfg_wr = 1'b1; cfg_run = run; cfg_load = load; cfg_pin_mode = mode;
        step(1);
        cfg_wr = 1'b0; cfg_load = 1'b0;
    endtask

    task automatic pulse(input int hi, input int lo);
        ext_pin = 1'b1; step(hi);
        ext_pin = 1'b0; step(lo);
    endtask

    task automatic trig_case(input logic [1:0] mode, input int exp_last, input string req);
        write_pre(6'd1, 1'b0, 1'b0);
        write_init(8'd50);
        write_cfg(1'b1, 1'b1, mode);
        step(4);
        check({req, " armed, no count"}, count_o, 50);
        ext_pin = 1'b1; step(10);
        check({req, " first trigger"}, count_o, 43);
        ext_pin = 1'b0; step(2);
        check({req, " running"}, count_o, 41);
        ext_pin = 1'b1; step(10);
        check({req, " second edge"}, count_o, exp_last);
        ext_pin = 1'b0; step(2);
    endtask

    initial begin
        step(2);
        check("R12 reset count", count_o, 0);
        check("R12 reset eoc", eoc_o, 0);
        rst_n = 1'b1;
        step(3);
        check("R12 idle after reset", count_o, 0);

        foreach (VEC[i]) begin
            write_pre(VEC[i].div, VEC[i].modulo, 1'b1);
            write_init(VEC[i].init);
            write_cfg(1'b1, 1'b1, 2'b00);
            step(int'(VEC[i].wait_n));
            check($sformatf("R1/R2/R3 vector %0d", i), count_o, VEC[i].exp);
        end

        // R4: pulse timing, single pass
        write_pre(6'd1, 1'b0, 1'b1);
        write_init(8'd3);
        write_cfg(1'b1, 1'b1, 2'b00);
        step(2);
        check("R4 no eoc before terminal", eoc_o, 0);
        step(1);
        check("R4 eoc after tick from 1", eoc_o, 1);
        check("R3 stopped at zero", count_o, 0);
        step(1);
        check("R4 eoc one cycle", eoc_o, 0);

        // R4: modulo pulses, init 2 -> eoc every second edge
        write_pre(6'd1, 1'b1, 1'b1);
        write_init(8'd2);
        write_cfg(1'b1, 1'b1, 2'b00);
        begin
            int seen = 0;
            for (int k = 0; k < 10; k++) begin
                step(1);
                if (eoc_o) seen++;
            end
            check("R4 modulo eoc count", seen, 5);
        end

        // R6, R5, R7: freeze, load bit 0, init write
        write_pre(6'd1, 1'b0, 1'b1);
        write_init(8'd9);
        write_cfg(1'b1, 1'b1, 2'b00);
        step(2);
        check("R6 running", count_o, 7);
        write_cfg(1'b0, 1'b0, 2'b00);
        step(5);
        check("R6 frozen", count_o, 6);
        write_cfg(1'b1, 1'b0, 2'b00);
        step(2);
        check("R5 load bit 0 no reload", count_o, 4);
        write_init(8'd100);
        check("R7 readback is current count", count_o, 3);
        write_cfg(1'b1, 1'b1, 2'b00);
        check("R5 load copies init", count_o, 100);

        // R8: external clock, ratio 2, four pin edges -> two ticks
        write_pre(6'd2, 1'b0, 1'b0);
        write_init(8'd10);
        write_cfg(1'b1, 1'b1, 2'b00);
        for (int k = 0; k < 4; k++) pulse(3, 3);
        check("R8 pin edges clock", count_o, 8);

        // R9: gate
        write_pre(6'd1, 1'b0, 1'b0);
        write_init(8'd30);
        write_cfg(1'b1, 1'b1, 2'b01);
        step(5);
        check("R9 gate closed", count_o, 30);
        pulse(7, 3);
        check("R9 gate open 7 cycles", count_o, 23);

        trig_case(2'b10, 31, "R10");
        trig_case(2'b11, 43, "R11");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule